// File: doc/BRIEF.md
# Segmented Waveform Sequencer for a DAC Channel

This block feeds one parallel sample stream to a waveform DAC. It has two output modes. In direct mode, samples that arrive on a streaming input go to the output one cycle later. In sequence mode, the block composes an output waveform from a bank of stored segments.

Each segment is a slot in a descriptor table, and its slot number is its identifier. A descriptor gives a start address in a shared sample memory, a length in samples and a repeat count. A sequence list names segments by identifier, in any order and with repeats. A rising edge on the trigger walks the list once, so a stored gate waveform can be recalled as often as an experiment needs.

The host loads the sample memory, the descriptor table, the sequence list and a control word through one write port. A one-cycle done pulse marks the end of a run. A sticky overrun flag reports triggers that arrived while a run was already in progress.

Top module: `wfs_engine`

## Requirements
- R1: In direct mode (control bit 0 = 0), when the block is idle, `dac_data` equals `din_data` one clock after a cycle with `din_valid` high. It is zero one clock after a cycle with `din_valid` low.
- R2: In sequence mode, when no run is in progress, `dac_data` is zero whatever the streaming input does. In direct mode a trigger starts nothing, and `busy` stays low.
- R3: Host writes use `host_tgt` to pick the target: 0 = sample word at `host_addr`; 1 = descriptor at slot `host_addr[5:0]`, with start in bits [9:0], length in bits [20:10] and repeat count in bits [28:21]; 2 = list entry `host_addr[5:0]`, which takes the segment identifier from bits [5:0]; 3 = control. After a trigger rising edge in sequence mode, the output shows one zero cycle. Then, for each list entry in order, it shows one zero gap cycle followed by that segment's samples from consecutive addresses, wrapping modulo the memory depth.
- R4: A segment with repeat count N plays its samples N+1 times back to back, with no gap between the passes.
- R5: A list entry whose segment has length 0 adds only its zero gap cycle.
- R6: After the final sample, the output is zero for one cycle. In that cycle `done` is high for exactly one clock and `busy` is already low.
- R7: The control word sets the list length from bits [15:8], clamped to 64. With a list length of 0, a trigger gives a zero cycle followed by the done cycle.
- R8: A trigger rising edge while `busy` is high does not alter the run in progress. It sets `overrun`, which stays set until a control write with bit 1 high clears it. A new overrun in the same cycle as a clear keeps the flag set. The clear is accepted even during a run.
- R9: While `busy` is high, host writes to sample memory, descriptors, the list and the mode/length fields of the control word are discarded.
- R10: After reset, `dac_data`, `busy`, `done` and `overrun` are zero, the block is in direct mode, every descriptor has length 0 and the list length is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_tgt | input | 2 | Host write target select |
| host_addr | input | 10 | Host write address or index |
| host_wdata | input | 32 | Host write data |
| din_valid | input | 1 | Direct-mode sample valid |
| din_data | input | 16 | Direct-mode sample |
| trig | input | 1 | Playback trigger, rising edge active |
| dac_data | output | 16 | Registered sample to the DAC |
| busy | output | 1 | Sequence run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| overrun | output | 1 | Sticky flag for a trigger that arrived while busy |

## Verification
The assertions assume that reset is held for at least one clock before `trig` first rises. They also assume the host does not change the mode while a run is active; the block enforces this by discarding such writes. Sample-region overlap is left to the host: segments may share or wrap through the sample memory. The stimulus therefore picks start addresses anywhere in the 1024-word memory, keeps segment lengths at or below 8 and repeat counts at or below 3, and lowers the trigger between runs so that each run begins on a clean rising edge. Mid-run triggers and blocked writes come only from a directed case, and that case keeps the run long enough that they all land while `busy` is high.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
    localparam int SAMPLE_W   = 16;
    localparam int ADDR_W     = 10;
    localparam int NUM_SEG    = 64;
    localparam int LIST_DEPTH = 64;
    localparam int REP_W      = 8;
    localparam int HOST_W     = 32;

    localparam int SEG_ID_W   = $clog2(NUM_SEG);
    localparam int LIST_IDX_W = $clog2(LIST_DEPTH);
    localparam int LIST_LEN_W = $clog2(LIST_DEPTH + 1);
    localparam int LEN_W      = ADDR_W + 1;
    localparam int LEN_FLD_LO = 8;

    typedef enum logic [1:0] {
        TGT_SAMPLE  = 2'd0,
        TGT_SEGMENT = 2'd1,
        TGT_LIST    = 2'd2,
        TGT_CTRL    = 2'd3
    } host_tgt_e;

    typedef struct packed {
        logic [REP_W-1:0]  rep;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] start;
    } seg_desc_t;

    localparam int DESC_W = $bits(seg_desc_t);

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_SEG  = 2'd1,
        PS_PLAY = 2'd2,
        PS_DONE = 2'd3
    } play_state_e;

    function automatic seg_desc_t desc_from_word(input logic [HOST_W-1:0] w);
        return seg_desc_t'(w[DESC_W-1:0]);
    endfunction

    function automatic logic [LIST_LEN_W-1:0] clamp_len(input logic [7:0] v);
        if (v > 8'(LIST_DEPTH))
            return LIST_LEN_W'(LIST_DEPTH);
        return v[LIST_LEN_W-1:0];
    endfunction
endpackage

// File: rtl/wfs_sample_mem.sv
module wfs_sample_mem #(
    parameter int DATA_W = wfs_pkg::SAMPLE_W,
    parameter int AW     = wfs_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/wfs_host_regs.sv
module wfs_host_regs
    import wfs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_we,
    input  logic [1:0]            host_tgt,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [HOST_W-1:0]     host_wdata,
    input  logic                  busy,
    input  logic [LIST_IDX_W-1:0] list_idx,
    output seg_desc_t             seg_desc,
    output logic                  sample_we,
    output logic                  mode_seq,
    output logic [LIST_LEN_W-1:0] list_len,
    output logic                  ovr_clr
);
    host_tgt_e tgt;
    logic      wr_open;
    logic      seg_we;
    logic      list_we;
    logic      ctrl_we;

    seg_desc_t           seg_tab  [NUM_SEG];
    logic [SEG_ID_W-1:0] list_tab [LIST_DEPTH];

    assign tgt       = host_tgt_e'(host_tgt);
    assign wr_open   = host_we && !busy;
    assign sample_we = wr_open && (tgt == TGT_SAMPLE);
    assign seg_we    = wr_open && (tgt == TGT_SEGMENT);
    assign list_we   = wr_open && (tgt == TGT_LIST);
    assign ctrl_we   = wr_open && (tgt == TGT_CTRL);
    assign ovr_clr   = host_we && (tgt == TGT_CTRL) && host_wdata[1];

    genvar gs;
    generate
        for (gs = 0; gs < NUM_SEG; gs++) begin : g_seg_row
            always_ff @(posedge clk) begin
                if (rst)
                    seg_tab[gs] <= '0;
                else if (seg_we && host_addr[SEG_ID_W-1:0] == SEG_ID_W'(gs))
                    seg_tab[gs] <= desc_from_word(host_wdata);
            end
        end
        for (gs = 0; gs < LIST_DEPTH; gs++) begin : g_list_row
            always_ff @(posedge clk) begin
                if (rst)
                    list_tab[gs] <= '0;
                else if (list_we && host_addr[LIST_IDX_W-1:0] == LIST_IDX_W'(gs))
                    list_tab[gs] <= host_wdata[SEG_ID_W-1:0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_seq <= 1'b0;
            list_len <= '0;
        end else if (ctrl_we) begin
            mode_seq <= host_wdata[0];
            list_len <= clamp_len(host_wdata[LEN_FLD_LO +: 8]);
        end
    end

    assign seg_desc = seg_tab[list_tab[list_idx]];

    logic unused_host_bits;
    assign unused_host_bits = ^{host_wdata[HOST_W-1:DESC_W], host_wdata[LEN_FLD_LO-1:2],
                                host_addr[ADDR_W-1:SEG_ID_W]};
endmodule

// File: rtl/wfs_seq_ctrl.sv
module wfs_seq_ctrl
    import wfs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trig_rise,
    input  logic                  mode_seq,
    input  logic [LIST_LEN_W-1:0] list_len,
    input  seg_desc_t             seg_desc,
    input  logic                  ovr_clr,
    output logic [LIST_IDX_W-1:0] list_idx,
    output logic                  play,
    output logic [ADDR_W-1:0]     rd_addr,
    output logic                  busy,
    output logic                  done,
    output logic                  overrun
);
    play_state_e           state;
    logic [LIST_LEN_W-1:0] idx;
    logic [ADDR_W-1:0]     cur_start;
    logic [LEN_W-1:0]      cur_len;
    logic [LEN_W-1:0]      cnt;
    logic [REP_W-1:0]      rep_left;
    logic [ADDR_W-1:0]     addr;
    logic                  last_entry;
    logic                  pass_end;

    assign last_entry = (idx + LIST_LEN_W'(1)) == list_len;
    assign pass_end   = cnt == (cur_len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PS_IDLE;
            idx       <= '0;
            cur_start <= '0;
            cur_len   <= '0;
            cnt       <= '0;
            rep_left  <= '0;
            addr      <= '0;
            done      <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (trig_rise && state != PS_IDLE)
                overrun <= 1'b1;
            else if (ovr_clr)
                overrun <= 1'b0;

            case (state)
                PS_IDLE: begin
                    if (trig_rise && mode_seq) begin
                        idx   <= '0;
                        state <= (list_len == '0) ? PS_DONE : PS_SEG;
                    end
                end
                PS_SEG: begin
                    if (seg_desc.len == '0) begin
                        if (last_entry)
                            state <= PS_DONE;
                        else
                            idx <= idx + LIST_LEN_W'(1);
                    end else begin
                        cur_start <= seg_desc.start;
                        cur_len   <= seg_desc.len;
                        addr      <= seg_desc.start;
                        cnt       <= '0;
                        rep_left  <= seg_desc.rep;
                        state     <= PS_PLAY;
                    end
                end
                PS_PLAY: begin
                    if (pass_end) begin
                        if (rep_left == '0) begin
                            if (last_entry) begin
                                state <= PS_DONE;
                            end else begin
                                idx   <= idx + LIST_LEN_W'(1);
                                state <= PS_SEG;
                            end
                        end else begin
                            rep_left <= rep_left - REP_W'(1);
                            cnt      <= '0;
                            addr     <= cur_start;
                        end
                    end else begin
                        cnt  <= cnt + LEN_W'(1);
                        addr <= addr + ADDR_W'(1);
                    end
                end
                PS_DONE: begin
                    done  <= 1'b1;
                    state <= PS_IDLE;
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

    assign list_idx = idx[LIST_IDX_W-1:0];
    assign play     = state == PS_PLAY;
    assign rd_addr  = addr;
    assign busy     = state != PS_IDLE;
endmodule

// File: rtl/wfs_engine.sv
module wfs_engine
    import wfs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                host_we,
    input  logic [1:0]          host_tgt,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [HOST_W-1:0]   host_wdata,
    input  logic                din_valid,
    input  logic [SAMPLE_W-1:0] din_data,
    input  logic                trig,
    output logic [SAMPLE_W-1:0] dac_data,
    output logic                busy,
    output logic                done,
    output logic                overrun
);
    logic                  trig_q;
    logic                  trig_rise;
    seg_desc_t             seg_desc;
    logic                  sample_we;
    logic                  mode_seq;
    logic [LIST_LEN_W-1:0] list_len;
    logic                  ovr_clr;
    logic [LIST_IDX_W-1:0] list_idx;
    logic                  play;
    logic [ADDR_W-1:0]     rd_addr;
    logic [SAMPLE_W-1:0]   rd_sample;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig;
    end
    assign trig_rise = trig && !trig_q;

    wfs_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_tgt   (host_tgt),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .busy       (busy),
        .list_idx   (list_idx),
        .seg_desc   (seg_desc),
        .sample_we  (sample_we),
        .mode_seq   (mode_seq),
        .list_len   (list_len),
        .ovr_clr    (ovr_clr)
    );

    wfs_sample_mem #(.DATA_W(SAMPLE_W), .AW(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (sample_we),
        .waddr (host_addr),
        .wdata (host_wdata[SAMPLE_W-1:0]),
        .raddr (rd_addr),
        .rdata (rd_sample)
    );

    wfs_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .trig_rise (trig_rise),
        .mode_seq  (mode_seq),
        .list_len  (list_len),
        .seg_desc  (seg_desc),
        .ovr_clr   (ovr_clr),
        .list_idx  (list_idx),
        .play      (play),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .done      (done),
        .overrun   (overrun)
    );

    always_ff @(posedge clk) begin
        if (rst)
            dac_data <= '0;
        else if (play)
            dac_data <= rd_sample;
        else if (!busy && !mode_seq && din_valid)
            dac_data <= din_data;
        else
            dac_data <= '0;
    end
endmodule

// File: rtl/wfs_engine_chk.sv
module wfs_engine_chk
    import wfs_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                trig,
    input logic                busy,
    input logic                done,
    input logic                overrun,
    input logic                mode_seq,
    input logic                din_valid,
    input logic [SAMPLE_W-1:0] din_data,
    input logic [SAMPLE_W-1:0] dac_data,
    input logic                host_we,
    input logic [1:0]          host_tgt,
    input logic [HOST_W-1:0]   host_wdata
);
    logic clr_req;
    assign clr_req = host_we && host_tgt == 2'd3 && host_wdata[1];

    a_r1_direct_pass: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !busy && !mode_seq) |->
            dac_data == ($past(din_valid) ? $past(din_data) : '0));

    a_r2_seq_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (!busy && mode_seq) |=> dac_data == '0);

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r6_end_marks_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r8_overrun_set: assert property (@(posedge clk) disable iff (rst)
        ($rose(trig) && busy) |=> overrun);

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr_req) |=> overrun);
endmodule

bind wfs_engine wfs_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .trig       (trig),
    .busy       (busy),
    .done       (done),
    .overrun    (overrun),
    .mode_seq   (mode_seq),
    .din_valid  (din_valid),
    .din_data   (din_data),
    .dac_data   (dac_data),
    .host_we    (host_we),
    .host_tgt   (host_tgt),
    .host_wdata (host_wdata)
);

// File: tb/wfs_engine_bench.sv
module wfs_engine_bench;
    localparam int MEMD = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_tgt = 2'd0;
    logic [9:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        din_valid = 1'b0;
    logic [15:0] din_data = '0;
    logic        trig = 1'b0;
    logic [15:0] dac_data;
    logic        busy, done, overrun;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    logic [15:0] m_mem [MEMD];
    int          m_start [64];
    int          m_len [64];
    int          m_rep [64];
    int          m_list [64];
    int          m_llen = 0;
    logic [15:0] exp_s [4096];
    logic [15:0] cap_s [4096];
    int          exp_n;

    always #4 clk = ~clk;

    wfs_engine u_wfs_engine (
        .clk(clk), .rst(rst), .host_we(host_we), .host_tgt(host_tgt),
        .host_addr(host_addr), .host_wdata(host_wdata), .din_valid(din_valid),
        .din_data(din_data), .trig(trig), .dac_data(dac_data), .busy(busy),
        .done(done), .overrun(overrun)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not end actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic host_wr(input int tgt, input int addr, input int data);
        @(negedge clk);
        host_we = 1'b1; host_tgt = 2'(tgt); host_addr = 10'(addr); host_wdata = 32'(data);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_seg(input int id, input int st, input int ln, input int rp);
        m_start[id] = st; m_len[id] = ln; m_rep[id] = rp;
        host_wr(1, id, (rp << 21) | (ln << 10) | st);
    endtask

    task automatic set_ctrl(input int mode, input int llen, input int clr);
        host_wr(3, 0, (llen << 8) | (clr << 1) | mode);
        m_llen = (llen > 64) ? 64 : llen;
    endtask

    task automatic build_exp();
        exp_n = 0;
        exp_s[exp_n++] = '0;
        for (int e = 0; e < m_llen; e++) begin
            int id = m_list[e];
            exp_s[exp_n++] = '0;
            for (int r = 0; r <= m_rep[id] && m_len[id] > 0; r++)
                for (int i = 0; i < m_len[id]; i++)
                    exp_s[exp_n++] = m_mem[(m_start[id] + i) % MEMD];
        end
        exp_s[exp_n++] = '0;
    endtask

    // inject: retrigger and blocked writes while the run is busy
    task automatic run_seq(input bit inject, input string tag);
        int n = 0;
        bit got = 0;
        int bad = -1;
        build_exp();
        @(negedge clk);
        trig = 1'b1;
        while (!got && n < 3000) begin
            @(negedge clk);
            cap_s[n] = dac_data;
            if (done) got = 1;
            if (inject) begin
                case (n)
                    1: trig = 1'b0;
                    2: trig = 1'b1;
                    3: begin trig = 1'b0; host_we = 1'b1; host_tgt = 2'd0;
                             host_addr = 10'(m_start[m_list[0]]);
                             host_wdata = 32'(~m_mem[m_start[m_list[0]]]); end
                    4: begin host_tgt = 2'd1; host_addr = 10'(m_list[0]);
                             host_wdata = 32'((9 << 10) | 500); end
                    5: begin host_tgt = 2'd2; host_addr = 10'd0; host_wdata = 32'd40; end
                    6: begin host_tgt = 2'd3; host_wdata = 32'((1 << 8) | 0); end
                    7: host_we = 1'b0;
                    default: ;
                endcase
            end
            n++;
        end
        trig = 1'b0;
        host_we = 1'b0;
        chk(n == exp_n, tag, "stream length", n, exp_n);
        for (int i = 0; i < n && i < exp_n; i++)
            if (bad < 0 && cap_s[i] !== exp_s[i]) bad = i;
        chk(bad < 0, tag, "stream sample", (bad < 0) ? 0 : cap_s[bad],
            (bad < 0) ? 0 : exp_s[bad]);
        @(negedge clk);
        chk(!done && !busy, "R6", "done lasts one cycle, busy low", {done, busy}, 0);
    endtask

    initial begin
        int seed_dummy;
        logic [15:0] prev_d;
        logic        prev_v;
        seed_dummy = $urandom(32'd20240);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(dac_data == 0, "R10", "dac after reset", dac_data, 0);
        chk(!busy && !done && !overrun, "R10", "flags after reset",
            {busy, done, overrun}, 0);

        // R1 direct mode is the reset mode
        prev_v = 0; prev_d = 0;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (k > 0)
                chk(dac_data == (prev_v ? prev_d : 16'h0), "R1", "direct output",
                    dac_data, prev_v ? prev_d : 16'h0);
            prev_v = 1'($urandom_range(0, 1));
            prev_d = 16'($urandom);
            din_valid = prev_v; din_data = prev_d;
        end
        din_valid = 1'b0;

        // R2 trigger in direct mode starts nothing
        @(negedge clk); trig = 1'b1;
        @(negedge clk); chk(!busy, "R2", "busy after trigger in direct mode", busy, 0);
        trig = 1'b0;

        // load sample memory
        for (int a = 0; a < MEMD; a++) begin
            m_mem[a] = 16'($urandom);
            host_wr(0, a, {16'h0, m_mem[a]});
        end
        for (int s = 0; s < 64; s++) begin m_start[s] = 0; m_len[s] = 0; m_rep[s] = 0; end
        for (int s = 0; s < 64; s++) m_list[s] = 0;

        // directed: R3 order, R4 repeats, R5 empty segment
        set_seg(3, 100, 4, 0);
        set_seg(5, 1022, 3, 2);
        set_seg(7, 300, 0, 1);
        m_list[0] = 3; host_wr(2, 0, 3);
        m_list[1] = 5; host_wr(2, 1, 5);
        m_list[2] = 7; host_wr(2, 2, 7);
        m_list[3] = 3; host_wr(2, 3, 3);
        set_ctrl(1, 4, 0);

        // R2 sequence mode idle ignores streaming input
        din_valid = 1'b1; din_data = 16'hBEEF;
        @(negedge clk); @(negedge clk);
        chk(dac_data == 0, "R2", "sequence idle output", dac_data, 0);
        din_valid = 1'b0;

        run_seq(0, "R3");
        run_seq(0, "R4");

        // R8 and R9: retrigger and writes while busy
        run_seq(1, "R8");
        chk(overrun == 1'b1, "R8", "overrun after busy trigger", overrun, 1);
        @(negedge clk);
        chk(overrun == 1'b1, "R8", "overrun sticky", overrun, 1);
        run_seq(0, "R9");
        set_ctrl(1, 4, 1);
        @(negedge clk);
        chk(overrun == 1'b0, "R8", "overrun cleared", overrun, 0);

        // R7 empty list, and length clamp
        set_ctrl(1, 0, 0);
        run_seq(0, "R7");
        for (int e = 4; e < 64; e++) begin
            m_list[e] = 7; host_wr(2, e, 7);
        end
        set_ctrl(1, 200, 0);
        chk(m_llen == 64, "R7", "model clamp", m_llen, 64);
        run_seq(0, "R7");

        // R5 empty-only list
        m_list[0] = 7; host_wr(2, 0, 7);
        set_ctrl(1, 1, 0);
        run_seq(0, "R5");

        // random compositions: R3 R4 R5
        for (int round = 0; round < 16; round++) begin
            int ids [8];
            int ll;
            for (int j = 0; j < 8; j++) begin
                ids[j] = $urandom_range(0, 63);
                set_seg(ids[j], $urandom_range(0, 1023),
                        ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(1, 8),
                        $urandom_range(0, 3));
            end
            ll = $urandom_range(1, 12);
            for (int e = 0; e < ll; e++) begin
                m_list[e] = ids[$urandom_range(0, 7)];
                host_wr(2, e, m_list[e]);
            end
            set_ctrl(1, ll, 0);
            run_seq(0, "R3");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule